// File: doc/BRIEF.md
# Character Display Instruction Executor

This block is the command engine of a character display controller. A host interface hands it one byte at a time, marked as either an instruction or a data byte. Instructions update the mode registers, the address counter, the display shift offset or the stored analog settings. Data bytes are written to whichever RAM the last address-set instruction selected. The RAMs are the display character RAM, the character pattern RAM or the icon RAM. All writes leave through one registered write port with a separate strobe per RAM. The address counter then steps up or down, following the line layout.

In two-line mode the display RAM is not contiguous. Line one occupies 00H to 27H and line two occupies 40H to 67H, and the counter jumps across the gap. Clear display is the only multi-cycle instruction. It walks every display RAM address of the current layout, one per cycle, writing the space code 20H. While it runs, the busy output is high and any incoming byte is dropped. A bank bit in the function set instruction swaps the meaning of codes 10H to 1FH and 40H to 7FH for an extension table. That table holds oscillator, bias, icon, booster, follower and contrast settings.

Top module: `chr_disp_exec`

## Requirements
- R1: Reset gives address counter 00H, offset 0, increment on, shift off, display/cursor/blink off, 8-bit bus, one line, normal table, busy low, no strobes. An instruction is decoded by its highest set bit: 01H clear, 02H-03H home, 04H-07H entry mode, 08H-0FH display control, 10H-1FH shift (or extension oscillator), 20H-3FH function set, 40H-7FH pattern address (or extension settings), 80H-FFH display address.
- R2: Clear display writes 20H once to each of the 80 display addresses of the current layout, one per cycle, with busy high for exactly those 80 cycles. It also sets the counter to 00H, the offset to 0 and increment mode on.
- R3: While busy is high, every input byte is ignored. It causes no strobe and no counter change.
- R4: Return home (02H/03H) sets the counter to 00H and the offset to 0, and writes nothing.
- R5: A data byte is written at the current counter value, on exactly one strobe: ram_we_disp, ram_we_patt or ram_we_icon. The counter then steps up when increment mode (bit 1 of entry mode) is 1, and down otherwise.
- R6: With shift-on-write (bit 0 of entry mode) set, a display RAM write moves the offset by one: +1 (left) when incrementing, -1 (right) when decrementing. Pattern and icon writes never move it.
- R7: In one-line mode the display counter wraps 4FH↔00H. In two-line mode it steps 27H→40H and 67H→00H going up, and 40H→27H and 00H→67H going down. A clear sweep in two-line mode never writes 28H-3FH.
- R8: Shift instruction 0001 SC RL xx: with SC=1 the offset moves (RL=1 right: -1, RL=0 left: +1, modulo 40 in two-line and 80 in one-line) and the counter is kept. With SC=0 the counter steps up (RL=1) or down (RL=0).
- R9: Function set 001 DL N DH x IS sets bus width (bit 4), two-line (bit 3), double height (bit 2) and the extension table (bit 0). Double height requested with N=1 is stored as 0.
- R10: With the extension table on, 0001 BS F2 F1 F0 sets bias (bit 3) and oscillator trim (bits 2:0). 0100 AAAA selects the icon RAM at address AAAA. 0101 ION BON C5 C4 sets icon, booster and contrast[5:4]. 0110 FON R2 R1 R0 sets the follower and the amplifier ratio. 0111 C3-C0 sets contrast[3:0]. None of these moves the counter or offset, and codes below 10H, 20H-3FH and 80H+ keep their normal meaning.
- R11: Display control 00001 D C B sets display on (bit 2), cursor (bit 1) and blink (bit 0).
- R12: 1AAAAAAA selects the display RAM and loads the counter with AAAAAAA. 01AAAAAA (normal table) selects the pattern RAM and loads AAAAAA. Pattern addresses wrap modulo 64 and icon addresses modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte present this cycle |
| in_rs | input | 1 | 1 = data byte, 0 = instruction |
| in_byte | input | 8 | Instruction or data byte |
| busy | output | 1 | Clear sweep in progress; input ignored |
| ram_we_disp | output | 1 | Write strobe, display character RAM |
| ram_we_patt | output | 1 | Write strobe, character pattern RAM |
| ram_we_icon | output | 1 | Write strobe, icon RAM |
| ram_addr | output | 7 | Write address |
| ram_wdata | output | 8 | Write data |
| addr_ctr | output | 7 | Address counter |
| disp_ofs | output | 7 | Display shift offset, positions left |
| inc_mode | output | 1 | Counter increments after a write |
| shift_mode | output | 1 | Display shifts on display RAM write |
| disp_on | output | 1 | Display enable |
| cur_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_8bit | output | 1 | 8-bit host bus selected |
| two_line | output | 1 | Two-line layout |
| dbl_height | output | 1 | Double-height font (effective) |
| ext_table | output | 1 | Extension instruction table active |
| icon_on | output | 1 | Icon display enable |
| boost_on | output | 1 | Booster enable |
| follow_on | output | 1 | Follower enable |
| bias_quarter | output | 1 | Quarter bias selected |
| osc_trim | output | 3 | Oscillator trim |
| amp_ratio | output | 3 | Reference amplifier ratio |
| contrast | output | 6 | Contrast setting |

## Verification
Two things share one cycle when a display RAM write lands with shift-on-write set and the counter at a line end. The counter crosses the two-line gap (27H to 40H) and the offset moves in the same edge. The bench sets this up and then reads both outputs after that single edge. A second collision comes from a byte that arrives in the middle of a clear sweep. The bench injects an instruction in one-line mode and a data byte in two-line mode partway through each sweep. It then confirms that exactly 80 space writes occur on the expected addresses and that the counter still reads 00H when busy drops.

// File: rtl/chr_exec_pkg.sv
// Shared types for the character display instruction executor.
// Assumes: 8-bit instruction bytes; three write targets.
package chr_exec_pkg;
    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DCTRL, OP_SHIFT, OP_FUNC,
        OP_PADDR, OP_DADDR, OP_OSC, OP_IADDR, OP_POWER, OP_FOLLOW, OP_CLOW
    } op_e;

    typedef enum logic [1:0] {TGT_DISP, TGT_PATT, TGT_ICON} tgt_e;

    localparam logic [7:0] SPACE_CODE = 8'h20;
endpackage

// File: rtl/chr_op_decode.sv
// Instruction decoder: classifies a byte by the position of its highest set
// bit, with the bank bit remapping 10H-1FH and 40H-7FH.
// Assumes: purely combinational, no state.
module chr_op_decode
    import chr_exec_pkg::*;
(
    input  logic [7:0] code,
    input  logic       ext,
    output op_e        op
);
    // Priority decode on the leading one.
    always_comb begin
        casez (code)
            8'b1???????: op = OP_DADDR;
            8'b01??????: begin
                if (!ext)                   op = OP_PADDR;
                else begin
                    case (code[5:4])
                        2'b00:   op = OP_IADDR;
                        2'b01:   op = OP_POWER;
                        2'b10:   op = OP_FOLLOW;
                        default: op = OP_CLOW;
                    endcase
                end
            end
            8'b001?????: op = OP_FUNC;
            8'b0001????: op = ext ? OP_OSC : OP_SHIFT;
            8'b00001???: op = OP_DCTRL;
            8'b000001??: op = OP_ENTRY;
            8'b0000001?: op = OP_HOME;
            8'b00000001: op = OP_CLEAR;
            default:     op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/chr_ac_step.sv
// Address counter stepper: next counter value one position up or down,
// honouring the layout of the selected RAM (line gap, wrap points).
// Assumes: PAT_AW and ICON_AW are not wider than DISP_AW.
module chr_ac_step
    import chr_exec_pkg::*;
#(
    parameter int DISP_AW    = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int PAT_AW     = 6,
    parameter int ICON_AW    = 4
) (
    input  logic [DISP_AW-1:0] ac,
    input  tgt_e               tgt,
    input  logic               two_line,
    input  logic               up,
    output logic [DISP_AW-1:0] nxt
);
    localparam logic [DISP_AW-1:0] ONE_LAST = DISP_AW'(2*LINE_LEN - 1);
    localparam logic [DISP_AW-1:0] L1_LAST  = DISP_AW'(LINE_LEN - 1);
    localparam logic [DISP_AW-1:0] L2_FIRST = DISP_AW'(LINE2_BASE);
    localparam logic [DISP_AW-1:0] L2_LAST  = DISP_AW'(LINE2_BASE + LINE_LEN - 1);

    logic [PAT_AW-1:0]  pat_n;
    logic [ICON_AW-1:0] icon_n;

    // Narrow counters for the pattern and icon RAMs wrap on their own width.
    always_comb begin
        pat_n  = up ? ac[PAT_AW-1:0] + 1'b1 : ac[PAT_AW-1:0] - 1'b1;
        icon_n = up ? ac[ICON_AW-1:0] + 1'b1 : ac[ICON_AW-1:0] - 1'b1;
    end

    // Select the wrap rule of the current target and layout.
    always_comb begin
        case (tgt)
            TGT_PATT: nxt = DISP_AW'(pat_n);
            TGT_ICON: nxt = DISP_AW'(icon_n);
            default: begin
                if (!two_line) begin
                    if (up) nxt = (ac == ONE_LAST) ? '0 : ac + 1'b1;
                    else    nxt = (ac == '0) ? ONE_LAST : ac - 1'b1;
                end else if (up) begin
                    if (ac == L1_LAST)      nxt = L2_FIRST;
                    else if (ac == L2_LAST) nxt = '0;
                    else                    nxt = ac + 1'b1;
                end else begin
                    if (ac == L2_FIRST)     nxt = L1_LAST;
                    else if (ac == '0)      nxt = L2_LAST;
                    else                    nxt = ac - 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/chr_clear_sweep.sv
// Clear sweep sequencer: after a start pulse, presents each display address
// of the current layout once per cycle while active is high.
// Assumes: start is not raised while active (the top drops input while busy).
module chr_clear_sweep #(
    parameter int DISP_AW    = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               two_line,
    output logic               active,
    output logic [DISP_AW-1:0] wr_addr
);
    localparam int CNT   = 2 * LINE_LEN;
    localparam int IDX_W = $clog2(CNT);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CNT - 1);
    localparam logic [IDX_W-1:0] IDX_L2   = IDX_W'(LINE_LEN);

    logic [IDX_W-1:0] idx;

    // Sweep index counter; runs CNT cycles after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == IDX_LAST) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
        end
    end

    // Map the index onto the layout, skipping the gap in two-line mode.
    always_comb begin
        if (two_line && idx >= IDX_L2)
            wr_addr = DISP_AW'(idx) - DISP_AW'(LINE_LEN) + DISP_AW'(LINE2_BASE);
        else
            wr_addr = DISP_AW'(idx);
    end

    AST_SWEEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> idx <= IDX_LAST);                                       // R2
    AST_SWEEP_SKIPS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && two_line) |-> !(wr_addr >= DISP_AW'(LINE_LEN) &&
                                   wr_addr <  DISP_AW'(LINE2_BASE)));      // R7
endmodule

// File: rtl/chr_disp_exec.sv
// Character display instruction executor (top). Accepts instruction and data
// bytes, keeps mode registers, address counter and shift offset, and issues
// one registered RAM write per cycle.
// Assumes: a byte is offered for one cycle with in_valid; bytes during busy
// are dropped, so the host waits for busy low.
module chr_disp_exec
    import chr_exec_pkg::*;
#(
    parameter int DISP_AW    = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int PAT_AW     = 6,
    parameter int ICON_AW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_rs,
    input  logic [7:0]         in_byte,
    output logic               busy,
    output logic               ram_we_disp,
    output logic               ram_we_patt,
    output logic               ram_we_icon,
    output logic [DISP_AW-1:0] ram_addr,
    output logic [7:0]         ram_wdata,
    output logic [DISP_AW-1:0] addr_ctr,
    output logic [DISP_AW-1:0] disp_ofs,
    output logic               inc_mode,
    output logic               shift_mode,
    output logic               disp_on,
    output logic               cur_on,
    output logic               blink_on,
    output logic               bus_8bit,
    output logic               two_line,
    output logic               dbl_height,
    output logic               ext_table,
    output logic               icon_on,
    output logic               boost_on,
    output logic               follow_on,
    output logic               bias_quarter,
    output logic [2:0]         osc_trim,
    output logic [2:0]         amp_ratio,
    output logic [5:0]         contrast
);
    localparam logic [DISP_AW-1:0] OFS_MAX1 = DISP_AW'(2*LINE_LEN - 1);
    localparam logic [DISP_AW-1:0] OFS_MAX2 = DISP_AW'(LINE_LEN - 1);
    localparam logic [DISP_AW-1:0] L1_LAST  = DISP_AW'(LINE_LEN - 1);
    localparam logic [DISP_AW-1:0] L2_FIRST = DISP_AW'(LINE2_BASE);

    op_e                op;
    tgt_e               tgt_q;
    logic [DISP_AW-1:0] ac_q, ofs_q, ac_nxt, sw_addr;
    logic [DISP_AW-1:0] ofs_max, ofs_lft, ofs_rgt;
    logic               id_q, sh_q, two_q, dh_q, ext_q, sw_active;
    logic               accept, is_cmd, is_dat, step_up;

    // Input qualification: nothing is taken while the sweep runs.
    always_comb begin
        accept  = in_valid && !sw_active;
        is_cmd  = accept && !in_rs;
        is_dat  = accept && in_rs;
        step_up = is_dat ? id_q : in_byte[2];
    end

    chr_op_decode u_dec (
        .code (in_byte),
        .ext  (ext_q),
        .op   (op)
    );

    chr_ac_step #(
        .DISP_AW(DISP_AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE),
        .PAT_AW(PAT_AW), .ICON_AW(ICON_AW)
    ) u_step (
        .ac       (ac_q),
        .tgt      (tgt_q),
        .two_line (two_q),
        .up       (step_up),
        .nxt      (ac_nxt)
    );

    chr_clear_sweep #(
        .DISP_AW(DISP_AW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (is_cmd && op == OP_CLEAR),
        .two_line (two_q),
        .active   (sw_active),
        .wr_addr  (sw_addr)
    );

    // Shift offset arithmetic, modulo the visible line length.
    always_comb begin
        ofs_max = two_q ? OFS_MAX2 : OFS_MAX1;
        ofs_lft = (ofs_q >= ofs_max) ? '0 : ofs_q + 1'b1;
        ofs_rgt = (ofs_q == '0) ? ofs_max : ofs_q - 1'b1;
    end

    // Main state: RAM write port, counter, offset and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_disp <= 1'b0;  ram_we_patt <= 1'b0;  ram_we_icon <= 1'b0;
            ram_addr    <= '0;    ram_wdata   <= '0;
            ac_q  <= '0;  ofs_q <= '0;  tgt_q <= TGT_DISP;
            id_q  <= 1'b1; sh_q <= 1'b0;
            disp_on <= 1'b0; cur_on <= 1'b0; blink_on <= 1'b0;
            bus_8bit <= 1'b1; two_q <= 1'b0; dh_q <= 1'b0; ext_q <= 1'b0;
            icon_on <= 1'b0; boost_on <= 1'b0; follow_on <= 1'b0;
            bias_quarter <= 1'b0; osc_trim <= '0; amp_ratio <= '0; contrast <= '0;
        end else begin
            ram_we_disp <= 1'b0;
            ram_we_patt <= 1'b0;
            ram_we_icon <= 1'b0;
            if (sw_active) begin
                ram_we_disp <= 1'b1;
                ram_addr    <= sw_addr;
                ram_wdata   <= SPACE_CODE;
            end else if (is_dat) begin
                case (tgt_q)
                    TGT_PATT: ram_we_patt <= 1'b1;
                    TGT_ICON: ram_we_icon <= 1'b1;
                    default:  ram_we_disp <= 1'b1;
                endcase
                ram_addr  <= ac_q;
                ram_wdata <= in_byte;
                ac_q      <= ac_nxt;
                if (tgt_q == TGT_DISP && sh_q)
                    ofs_q <= id_q ? ofs_lft : ofs_rgt;
            end else if (is_cmd) begin
                case (op)
                    OP_CLEAR, OP_HOME: begin
                        ac_q  <= '0;
                        ofs_q <= '0;
                        tgt_q <= TGT_DISP;
                        if (op == OP_CLEAR) id_q <= 1'b1;
                    end
                    OP_ENTRY: begin id_q <= in_byte[1]; sh_q <= in_byte[0]; end
                    OP_DCTRL: begin
                        disp_on  <= in_byte[2];
                        cur_on   <= in_byte[1];
                        blink_on <= in_byte[0];
                    end
                    OP_SHIFT: begin
                        if (in_byte[3]) ofs_q <= in_byte[2] ? ofs_rgt : ofs_lft;
                        else            ac_q  <= ac_nxt;
                    end
                    OP_FUNC: begin
                        bus_8bit <= in_byte[4];
                        two_q    <= in_byte[3];
                        dh_q     <= in_byte[2] & ~in_byte[3];
                        ext_q    <= in_byte[0];
                    end
                    OP_PADDR: begin tgt_q <= TGT_PATT; ac_q <= DISP_AW'(in_byte[PAT_AW-1:0]); end
                    OP_DADDR: begin tgt_q <= TGT_DISP; ac_q <= in_byte[DISP_AW-1:0]; end
                    OP_IADDR: begin tgt_q <= TGT_ICON; ac_q <= DISP_AW'(in_byte[ICON_AW-1:0]); end
                    OP_OSC:   begin bias_quarter <= in_byte[3]; osc_trim <= in_byte[2:0]; end
                    OP_POWER: begin
                        icon_on       <= in_byte[3];
                        boost_on      <= in_byte[2];
                        contrast[5:4] <= in_byte[1:0];
                    end
                    OP_FOLLOW: begin follow_on <= in_byte[3]; amp_ratio <= in_byte[2:0]; end
                    OP_CLOW:   contrast[3:0] <= in_byte[3:0];
                    default: ;
                endcase
            end
        end
    end

    // Output mapping of internal state.
    always_comb begin
        busy       = sw_active;
        addr_ctr   = ac_q;
        disp_ofs   = ofs_q;
        inc_mode   = id_q;
        shift_mode = sh_q;
        two_line   = two_q;
        dbl_height = dh_q;
        ext_table  = ext_q;
    end

    AST_BUSY_HOLDS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> $stable(ac_q));                             // R3
    AST_SWEEP_NO_OTHER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ram_we_patt && !ram_we_icon));                          // R3
    AST_SWEEP_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && ram_we_disp) |-> ram_wdata == SPACE_CODE);         // R2
    AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == OP_HOME) |=> (ac_q == '0 && ofs_q == '0));        // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we_disp, ram_we_patt, ram_we_icon}));                // R5
    AST_PAT_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && tgt_q != TGT_DISP) |=> $stable(ofs_q));                 // R6
    AST_LINE_GAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && tgt_q == TGT_DISP && two_q && id_q && ac_q == L1_LAST)
        |=> ac_q == L2_FIRST);                                             // R7
    AST_SCREEN_SHIFT_KEEPS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == OP_SHIFT && in_byte[3]) |=> $stable(ac_q));       // R8
    AST_DH_FORBIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(two_q && dh_q));                                                 // R9
endmodule

// File: tb/sim_chr_disp_exec.sv
`timescale 1ns/1ps
module sim_chr_disp_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_rs = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       busy, ram_we_disp, ram_we_patt, ram_we_icon;
    logic [6:0] ram_addr, addr_ctr, disp_ofs;
    logic [7:0] ram_wdata;
    logic       inc_mode, shift_mode, disp_on, cur_on, blink_on, bus_8bit;
    logic       two_line, dbl_height, ext_table, icon_on, boost_on, follow_on;
    logic       bias_quarter;
    logic [2:0] osc_trim, amp_ratio;
    logic [5:0] contrast;

    int n_chk = 0, n_fail = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;

    chr_disp_exec u0 (.*);

    typedef struct packed {
        logic       rs;  logic [7:0] b;  logic [6:0] ac;  logic [6:0] ofs;
        logic [2:0] we;  logic [6:0] addr; logic [3:0] req;
    } vec_t;
    // we: {icon, patt, disp}
    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1'b0,8'hCE,7'h4E,7'h00,3'd0,7'h00,4'd12},  // R12 display address
        '{1'b1,8'h41,7'h4F,7'h00,3'd1,7'h4E,4'd5},   // R5
        '{1'b1,8'h42,7'h00,7'h00,3'd1,7'h4F,4'd7},   // R7 one-line wrap up
        '{1'b0,8'h04,7'h00,7'h00,3'd0,7'h00,4'd5},
        '{1'b1,8'h43,7'h4F,7'h00,3'd1,7'h00,4'd7},   // R7 wrap down
        '{1'b0,8'h07,7'h4F,7'h00,3'd0,7'h00,4'd6},
        '{1'b1,8'h44,7'h00,7'h01,3'd1,7'h4F,4'd6},   // R6 shift left
        '{1'b0,8'h05,7'h00,7'h01,3'd0,7'h00,4'd6},
        '{1'b1,8'h45,7'h4F,7'h00,3'd1,7'h00,4'd6},   // R6 shift right
        '{1'b0,8'h7F,7'h3F,7'h00,3'd0,7'h00,4'd12},  // pattern address
        '{1'b1,8'h1F,7'h3E,7'h00,3'd2,7'h3F,4'd6},   // pattern write, no shift
        '{1'b0,8'h06,7'h3E,7'h00,3'd0,7'h00,4'd5},
        '{1'b1,8'h00,7'h3F,7'h00,3'd2,7'h3E,4'd5},
        '{1'b1,8'h00,7'h00,7'h00,3'd2,7'h3F,4'd12},  // 64 wrap
        '{1'b0,8'h14,7'h01,7'h00,3'd0,7'h00,4'd8},   // R8 cursor right
        '{1'b0,8'h38,7'h01,7'h00,3'd0,7'h00,4'd9},
        '{1'b0,8'hA7,7'h27,7'h00,3'd0,7'h00,4'd12},
        '{1'b1,8'h30,7'h40,7'h00,3'd1,7'h27,4'd7},   // line gap up
        '{1'b0,8'hE7,7'h67,7'h00,3'd0,7'h00,4'd12},
        '{1'b1,8'h31,7'h00,7'h00,3'd1,7'h67,4'd7},
        '{1'b0,8'h04,7'h00,7'h00,3'd0,7'h00,4'd5},
        '{1'b1,8'h32,7'h67,7'h00,3'd1,7'h00,4'd7},
        '{1'b0,8'hC0,7'h40,7'h00,3'd0,7'h00,4'd12},
        '{1'b1,8'h33,7'h27,7'h00,3'd1,7'h40,4'd7},   // line gap down
        '{1'b0,8'h1C,7'h27,7'h27,3'd0,7'h00,4'd8},   // screen right, mod 40
        '{1'b0,8'h18,7'h27,7'h00,3'd0,7'h00,4'd8},
        '{1'b0,8'h18,7'h27,7'h01,3'd0,7'h00,4'd8},
        '{1'b0,8'h10,7'h26,7'h01,3'd0,7'h00,4'd8},
        '{1'b0,8'h03,7'h00,7'h00,3'd0,7'h00,4'd4},   // R4 home
        '{1'b0,8'h39,7'h00,7'h00,3'd0,7'h00,4'd9},
        '{1'b0,8'h4A,7'h0A,7'h00,3'd0,7'h00,4'd10},  // R10 icon address
        '{1'b1,8'h55,7'h09,7'h00,3'd4,7'h0A,4'd10},
        '{1'b0,8'h06,7'h09,7'h00,3'd0,7'h00,4'd5},
        '{1'b0,8'h4F,7'h0F,7'h00,3'd0,7'h00,4'd10},
        '{1'b1,8'h01,7'h00,7'h00,3'd4,7'h0F,4'd12},  // 16 wrap
        '{1'b0,8'h14,7'h00,7'h00,3'd0,7'h00,4'd10},  // ext: not a shift
        '{1'b0,8'h7F,7'h00,7'h00,3'd0,7'h00,4'd10},  // ext: not pattern addr
        '{1'b0,8'h85,7'h05,7'h00,3'd0,7'h00,4'd10},
        '{1'b0,8'h38,7'h05,7'h00,3'd0,7'h00,4'd9}
    };

    task automatic eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic rs, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_rs = rs; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_clear(input bit two, input string req);
        logic [127:0] seen = '0;
        int wr = 0, bad_data = 0, off_map = 0, busy_n = 0;
        put(1'b0, two ? 8'h38 : 8'h30);
        put(1'b0, 8'h04);
        put(1'b0, 8'h18);
        put(1'b0, 8'h85);
        @(negedge clk);
        in_valid = 1'b1; in_rs = 1'b0; in_byte = 8'h01;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = (i == 10);
            in_rs = two; in_byte = two ? 8'h5A : 8'h14;
            if (busy) busy_n++;
            if (ram_we_disp) begin
                wr++;
                if (ram_wdata != 8'h20) bad_data++;
                if (two ? !(ram_addr < 7'd40 || (ram_addr >= 7'h40 && ram_addr < 7'h68))
                        : !(ram_addr < 7'h50)) off_map++;
                seen[ram_addr] = 1'b1;
            end
        end
        in_valid = 1'b0;
        eq(req, "R2 clear write count", wr, 80);
        eq(req, "R2 distinct clear addresses", $countones(seen), 80);
        eq(req, "R2 clear data not space", bad_data, 0);
        eq(req, "R7 clear address off layout", off_map, 0);
        eq(req, "R2 busy cycles", busy_n, 80);
        eq(req, "R3 counter after sweep with dropped byte", addr_ctr, 0);
        eq(req, "R2 offset after clear", disp_ofs, 0);
        eq(req, "R2 increment after clear", inc_mode, 1);
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        eq("R1", "counter", addr_ctr, 0);
        eq("R1", "offset", disp_ofs, 0);
        eq("R1", "inc/shift", {inc_mode, shift_mode}, 2'b10);
        eq("R1", "display ctrl", {disp_on, cur_on, blink_on}, 0);
        eq("R1", "function", {bus_8bit, two_line, dbl_height, ext_table}, 4'b1000);
        eq("R1", "busy/strobes", {busy, ram_we_disp, ram_we_patt, ram_we_icon}, 0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_rs = VEC[k].rs; in_byte = VEC[k].b;
            @(negedge clk);
            in_valid = 1'b0;
            eq($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d counter", k), addr_ctr, VEC[k].ac);
            eq($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d offset", k), disp_ofs, VEC[k].ofs);
            eq($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d strobes", k),
               {ram_we_icon, ram_we_patt, ram_we_disp}, VEC[k].we);
            if (VEC[k].we != 3'd0) begin
                eq($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d addr", k), ram_addr, VEC[k].addr);
                eq($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d data", k), ram_wdata, VEC[k].b);
            end
        end

        // R10 extension settings
        put(1'b0, 8'h39); put(1'b0, 8'h1C); put(1'b0, 8'h5E);
        put(1'b0, 8'h6D); put(1'b0, 8'h73);
        eq("R10", "bias/osc", {bias_quarter, osc_trim}, 4'hC);
        eq("R10", "icon/boost/follow", {icon_on, boost_on, follow_on}, 3'b111);
        eq("R10", "amp ratio", amp_ratio, 5);
        eq("R10", "contrast", contrast, 6'h23);
        eq("R10", "counter untouched", addr_ctr, 5);

        // R11 display control
        put(1'b0, 8'h0F);
        eq("R11", "all on", {disp_on, cur_on, blink_on}, 3'b111);
        put(1'b0, 8'h0C);
        eq("R11", "display only", {disp_on, cur_on, blink_on}, 3'b100);

        // R9 function set fields and forbidden combination
        put(1'b0, 8'h2C);
        eq("R9", "DH with N=1", {bus_8bit, two_line, dbl_height, ext_table}, 4'b0100);
        put(1'b0, 8'h24);
        eq("R9", "DH with N=0", {bus_8bit, two_line, dbl_height}, 3'b001);

        // R6 R7 same-cycle line gap and display shift
        put(1'b0, 8'h38); put(1'b0, 8'h07); put(1'b0, 8'hA7);
        put(1'b1, 8'h61);
        eq("R7", "gap crossing with shift", addr_ctr, 7'h40);
        eq("R6", "shift on gap crossing", disp_ofs, 1);
        eq("R5", "write address at line end", ram_addr, 7'h27);

        // R1 decode: 02H is home, not clear
        put(1'b0, 8'h02);
        eq("R1", "02H no busy", busy, 0);
        eq("R4", "home writes nothing", {ram_we_disp, ram_we_patt, ram_we_icon}, 0);

        run_clear(1'b0, "R2 one-line");
        run_clear(1'b1, "R3 two-line");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule